// File: doc/BRIEF.md
# Per-Channel DMA Data Buffer with Sticky Error Flags

This block sits between a host-side DMA engine and a set of line ports. It holds one synchronous FIFO for every channel. Receive channels carry bytes from a port up to the host. Transmit channels carry bytes from the host down to a port. Each channel is switched on by its own bit in a 16-bit enable word. A global enable gates every channel at once.

Every channel runs a small state machine with three states. `CH_OFF` means the channel is disabled and its FIFO is flushed. `CH_RUN` means it is moving data with no error seen. `CH_FAULT` means at least one error has been latched since the channel was last enabled. The transitions are:

- `CH_OFF -> CH_RUN` when the channel becomes active.
- `CH_RUN -> CH_FAULT` on an overflow or underflow event.
- `CH_RUN -> CH_OFF` and `CH_FAULT -> CH_OFF` whenever the channel stops being active.

An overflow is a write into a full FIFO; the offered byte is dropped. An underflow is a port-side read of an empty transmit FIFO; the port keeps seeing the last good byte. Both error kinds set sticky bits in two 16-bit flag vectors. The only way to clear those bits is to disable the channel or drop the global enable.

Top module: `dma_chan_buf`

## Requirements
- R1: Receive channel i (i = 0..4) is active when `glb_en` is 1 and `chan_en[i]` is 1. Transmit channel i is active when `glb_en` is 1 and `chan_en[8+i]` is 1. A channel accepts data from the second cycle after it becomes active. Bytes offered while it is inactive are discarded.
- R2: Bytes written on the port side of receive channel i come out on the host side in order. They come out one per `rx_rd_req[i]` pulse. `rx_rd_vld[i]` is 1 with the byte on `rx_rd_data` lane i in the cycle after the request.
- R3: Bytes written by the host into transmit channel i come out in order on `tx_rd_data` lane i. Each byte appears in the cycle after the `tx_rd_req[i]` that pops it.
- R4: A `tx_rd_req[i]` to an empty, active transmit FIFO leaves `tx_rd_data` lane i holding the last byte it showed. It also sets `unf_flags[8+i]` in the next cycle.
- R5: Each FIFO holds DEPTH (default 16) bytes. A write to a full FIFO is dropped, and the stored bytes are unaffected. The write sets the overflow bit in the next cycle: `ovf_flags[i]` for receive channel i, `ovf_flags[8+i]` for transmit channel i.
- R6: Flag bits stay set while their channel remains active. Clearing one channel's enable bit clears only that channel's flags and resets its output byte to 0 in the next cycle.
- R7: Driving `glb_en` to 0 clears every flag bit in the next cycle and flushes all FIFOs.
- R8: No flag bit is set by traffic on an inactive channel. A host read of an empty receive FIFO gives no `rx_rd_vld` and sets no flag. Flag bits 5..7 and 13..15, and `unf_flags` bits 0..7, always read 0.
- R9: After an underflow, a new host byte written and then popped appears on the port lane. The underflow flag stays set.
- R10: After reset all flags are 0, every `tx_rd_data` lane is 0 and `rx_rd_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global enable for all channels |
| chan_en | input | 16 | Channel enables: bits 0-4 receive, bits 8-12 transmit |
| rx_wr_vld | input | 5 | Port-side write strobe per receive channel |
| rx_wr_data | input | 40 | Port-side write byte, one 8-bit lane per channel |
| rx_rd_req | input | 5 | Host-side pop request per receive channel |
| rx_rd_vld | output | 5 | Popped byte valid per receive channel |
| rx_rd_data | output | 40 | Popped receive bytes, one lane per channel |
| tx_wr_vld | input | 5 | Host-side write strobe per transmit channel |
| tx_wr_data | input | 40 | Host-side write byte, one lane per channel |
| tx_rd_req | input | 5 | Port-side pop request per transmit channel |
| tx_rd_data | output | 40 | Byte presented to each port (held on underflow) |
| ovf_flags | output | 16 | Sticky overflow flags, same bit layout as chan_en |
| unf_flags | output | 16 | Sticky underflow flags, transmit bits 8-12 only |

## Verification
The bound checker watches several rules on every cycle:
- dropping the global enable empties both flag vectors on the next cycle;
- a cleared channel bit empties that channel's flags;
- a set flag survives while its channel stays active;
- a flag can only rise on a channel that was active;
- unused flag positions stay zero;
- a transmit lane never moves without a pop;
- a receive valid only follows a request.

Data ordering, drop-on-full with intact contents, repetition of the last byte across underflow and recovery, and flushing through a global disable depend on what was written earlier. Only the bench's scenarios show these, by comparing popped bytes against expected sequences.

// File: rtl/dma_buf_pkg.sv
package dma_buf_pkg;

    // Per-channel control state
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,   // disabled, FIFO flushed, flags clear
        CH_RUN   = 2'd1,   // moving data, no error latched
        CH_FAULT = 2'd2    // moving data, at least one sticky error latched
    } ch_state_t;

endpackage

// File: rtl/dbuf_fifo.sv
module dbuf_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] pdata,
    input  logic          pop,
    output logic [DW-1:0] qdata,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] cnt;
    logic          do_w;
    logic          do_r;

    assign full  = (cnt == CNT_FULL);
    assign empty = (cnt == '0);
    assign do_w  = push && !full;
    assign do_r  = pop && !empty;
    assign qdata = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_w) begin
                wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            end
            if (do_r) begin
                rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
            end
            unique case ({do_w, do_r})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_w && !clr) begin
            mem[wp] <= pdata;
        end
    end

endmodule

// File: rtl/dbuf_chan.sv
module dbuf_chan
    import dma_buf_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter bit IS_TX = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          wr_vld,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_vld,
    output logic          ovf,
    output logic          unf
);
    ch_state_t     st_q;
    ch_state_t     st_d;
    logic          op_ok;
    logic          full;
    logic          empty;
    logic          do_push;
    logic          do_pop;
    logic          ovf_ev;
    logic          unf_ev;
    logic [DW-1:0] qdata;

    // Data moves only once the state machine has left CH_OFF.
    assign op_ok   = active && (st_q != CH_OFF);
    assign do_push = op_ok && wr_vld && !full;
    assign do_pop  = op_ok && rd_req && !empty;
    assign ovf_ev  = op_ok && wr_vld && full;

    generate
        if (IS_TX) begin : g_unf
            assign unf_ev = op_ok && rd_req && empty;
        end else begin : g_no_unf
            assign unf_ev = 1'b0;
        end
    endgenerate

    dbuf_fifo #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!op_ok),
        .push  (do_push),
        .pdata (wr_data),
        .pop   (do_pop),
        .qdata (qdata),
        .full  (full),
        .empty (empty)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF: begin
                if (active) st_d = CH_RUN;
            end
            CH_RUN: begin
                if (!active)              st_d = CH_OFF;
                else if (ovf_ev || unf_ev) st_d = CH_FAULT;
            end
            CH_FAULT: begin
                if (!active) st_d = CH_OFF;
            end
            default: st_d = CH_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    // Output registers: sticky flags and the presented byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf     <= 1'b0;
            unf     <= 1'b0;
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else if (st_d == CH_OFF) begin
            ovf     <= 1'b0;
            unf     <= 1'b0;
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            ovf    <= ovf | ovf_ev;
            unf    <= unf | unf_ev;
            rd_vld <= do_pop;
            if (do_pop) begin
                rd_data <= qdata;   // otherwise held: last good byte repeats
            end
        end
    end

endmodule

// File: rtl/dma_chan_buf.sv
module dma_chan_buf #(
    parameter int NPORT   = 5,
    parameter int DW      = 8,
    parameter int DEPTH   = 16,
    parameter int CEN_W   = 16,
    parameter int TX_BASE = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  glb_en,
    input  logic [CEN_W-1:0]      chan_en,
    input  logic [NPORT-1:0]      rx_wr_vld,
    input  logic [NPORT*DW-1:0]   rx_wr_data,
    input  logic [NPORT-1:0]      rx_rd_req,
    output logic [NPORT-1:0]      rx_rd_vld,
    output logic [NPORT*DW-1:0]   rx_rd_data,
    input  logic [NPORT-1:0]      tx_wr_vld,
    input  logic [NPORT*DW-1:0]   tx_wr_data,
    input  logic [NPORT-1:0]      tx_rd_req,
    output logic [NPORT*DW-1:0]   tx_rd_data,
    output logic [CEN_W-1:0]      ovf_flags,
    output logic [CEN_W-1:0]      unf_flags
);
    logic [NPORT-1:0] rx_ovf;
    logic [NPORT-1:0] rx_unf;
    logic [NPORT-1:0] tx_ovf;
    logic [NPORT-1:0] tx_unf;
    logic [NPORT-1:0] tx_vld;

    genvar gi;
    generate
        for (gi = 0; gi < NPORT; gi++) begin : g_ch
            dbuf_chan #(
                .DW    (DW),
                .DEPTH (DEPTH),
                .IS_TX (1'b0)
            ) u_rx (
                .clk     (clk),
                .rst_n   (rst_n),
                .active  (glb_en && chan_en[gi]),
                .wr_vld  (rx_wr_vld[gi]),
                .wr_data (rx_wr_data[gi*DW +: DW]),
                .rd_req  (rx_rd_req[gi]),
                .rd_data (rx_rd_data[gi*DW +: DW]),
                .rd_vld  (rx_rd_vld[gi]),
                .ovf     (rx_ovf[gi]),
                .unf     (rx_unf[gi])
            );

            dbuf_chan #(
                .DW    (DW),
                .DEPTH (DEPTH),
                .IS_TX (1'b1)
            ) u_tx (
                .clk     (clk),
                .rst_n   (rst_n),
                .active  (glb_en && chan_en[TX_BASE + gi]),
                .wr_vld  (tx_wr_vld[gi]),
                .wr_data (tx_wr_data[gi*DW +: DW]),
                .rd_req  (tx_rd_req[gi]),
                .rd_data (tx_rd_data[gi*DW +: DW]),
                .rd_vld  (tx_vld[gi]),
                .ovf     (tx_ovf[gi]),
                .unf     (tx_unf[gi])
            );
        end
    endgenerate

    // Flag vectors share the enable word's layout; other positions stay 0.
    always_comb begin
        ovf_flags = '0;
        unf_flags = '0;
        for (int i = 0; i < NPORT; i++) begin
            ovf_flags[i]           = rx_ovf[i];
            ovf_flags[TX_BASE + i] = tx_ovf[i];
            unf_flags[TX_BASE + i] = tx_unf[i];
        end
    end

    // Receive channels never raise underflow, and the transmit valid
    // strobes have no port; fold them into a sink to keep them referenced.
    logic unused_ok;
    assign unused_ok = ^{rx_unf, tx_vld};

endmodule

// File: rtl/dma_chan_buf_chk.sv
module dma_chan_buf_chk #(
    parameter int NPORT   = 5,
    parameter int DW      = 8,
    parameter int CEN_W   = 16,
    parameter int TX_BASE = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                glb_en,
    input logic [CEN_W-1:0]    chan_en,
    input logic [NPORT-1:0]    rx_rd_req,
    input logic [NPORT-1:0]    rx_rd_vld,
    input logic [NPORT-1:0]    tx_rd_req,
    input logic [NPORT*DW-1:0] tx_rd_data,
    input logic [CEN_W-1:0]    ovf_flags,
    input logic [CEN_W-1:0]    unf_flags
);
    localparam logic [CEN_W-1:0] RX_MASK = CEN_W'((1 << NPORT) - 1);
    localparam logic [CEN_W-1:0] TX_MASK = RX_MASK << TX_BASE;

    // R7: global disable empties both flag vectors
    p_global_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (ovf_flags == '0) && (unf_flags == '0));

    // R8: unused flag positions read zero
    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_flags & ~(RX_MASK | TX_MASK)) == '0) && ((unf_flags & ~TX_MASK) == '0));

    genvar gi;
    generate
        for (gi = 0; gi < NPORT; gi++) begin : g_chk
            // R6: sticky while active
            p_sticky_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (ovf_flags[gi] && glb_en && chan_en[gi]) |=> ovf_flags[gi]);
            p_sticky_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (unf_flags[TX_BASE+gi] && glb_en && chan_en[TX_BASE+gi]) |=> unf_flags[TX_BASE+gi]);
            // R6: channel disable clears its flags
            p_chan_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !chan_en[TX_BASE+gi] |=> !ovf_flags[TX_BASE+gi] && !unf_flags[TX_BASE+gi]);
            // R8: a flag only rises on an active channel
            p_rise_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(ovf_flags[gi]) |-> $past(glb_en && chan_en[gi]));
            // R4: transmit lane moves only on a pop
            p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (glb_en && chan_en[TX_BASE+gi] && !tx_rd_req[gi]) |=> $stable(tx_rd_data[gi*DW +: DW]));
            // R2: receive valid only follows a request
            p_rx_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
                rx_rd_vld[gi] |-> $past(rx_rd_req[gi]));
        end
    endgenerate

endmodule

bind dma_chan_buf dma_chan_buf_chk #(
    .NPORT   (NPORT),
    .DW      (DW),
    .CEN_W   (CEN_W),
    .TX_BASE (TX_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .glb_en     (glb_en),
    .chan_en    (chan_en),
    .rx_rd_req  (rx_rd_req),
    .rx_rd_vld  (rx_rd_vld),
    .tx_rd_req  (tx_rd_req),
    .tx_rd_data (tx_rd_data),
    .ovf_flags  (ovf_flags),
    .unf_flags  (unf_flags)
);

// File: tb/sim_dma_chan_buf.sv
module sim_dma_chan_buf;
    localparam int NP    = 5;
    localparam int DEPTH = 16;
    localparam int NV    = 14;
    // Encoding: [15:14] op (0 rx push, 1 rx pop+check, 2 tx push, 3 tx pop+check),
    // [12:10] channel, [7:0] byte
    localparam logic [15:0] VEC [NV] = '{
        16'h0011, 16'h0022, 16'h0833, 16'h4011, 16'h4833, 16'h4022,
        16'h84A5, 16'h845A, 16'hC4A5, 16'hC45A,
        16'h1044, 16'h5044, 16'h9099, 16'hD099
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          glb_en = 1'b0;
    logic [15:0]   chan_en = '0;
    logic [NP-1:0] rx_wr_vld = '0;
    logic [NP*8-1:0] rx_wr_data = '0;
    logic [NP-1:0] rx_rd_req = '0;
    logic [NP-1:0] rx_rd_vld;
    logic [NP*8-1:0] rx_rd_data;
    logic [NP-1:0] tx_wr_vld = '0;
    logic [NP*8-1:0] tx_wr_data = '0;
    logic [NP-1:0] tx_rd_req = '0;
    logic [NP*8-1:0] tx_rd_data;
    logic [15:0]   ovf_flags;
    logic [15:0]   unf_flags;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    dma_chan_buf u0 (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .chan_en(chan_en),
        .rx_wr_vld(rx_wr_vld), .rx_wr_data(rx_wr_data), .rx_rd_req(rx_rd_req),
        .rx_rd_vld(rx_rd_vld), .rx_rd_data(rx_rd_data),
        .tx_wr_vld(tx_wr_vld), .tx_wr_data(tx_wr_data), .tx_rd_req(tx_rd_req),
        .tx_rd_data(tx_rd_data), .ovf_flags(ovf_flags), .unf_flags(unf_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic rx_push(input int ch, input logic [7:0] d);
        rx_wr_vld[ch] = 1'b1;
        rx_wr_data[ch*8 +: 8] = d;
        @(negedge clk);
        rx_wr_vld = '0;
    endtask

    task automatic rx_pop(input int ch);
        rx_rd_req[ch] = 1'b1;
        @(negedge clk);
        rx_rd_req = '0;
    endtask

    task automatic tx_push(input int ch, input logic [7:0] d);
        tx_wr_vld[ch] = 1'b1;
        tx_wr_data[ch*8 +: 8] = d;
        @(negedge clk);
        tx_wr_vld = '0;
    endtask

    task automatic tx_pop(input int ch);
        tx_rd_req[ch] = 1'b1;
        @(negedge clk);
        tx_rd_req = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R10: reset state
        check("R10 ovf", 32'(ovf_flags), 32'h0);
        check("R10 unf", 32'(unf_flags), 32'h0);
        check("R10 txdata", 32'(tx_rd_data[31:0]), 32'h0);
        check("R10 rxvld", 32'(rx_rd_vld), 32'h0);

        glb_en  = 1'b1;
        chan_en = 16'h1F1F;
        idle();

        // Table walk: R2 (rx order) and R3 (tx order)
        for (int k = 0; k < NV; k++) begin
            int ch;
            logic [7:0] d;
            ch = int'(VEC[k][12:10]);
            d  = VEC[k][7:0];
            unique case (VEC[k][15:14])
                2'd0: rx_push(ch, d);
                2'd1: begin
                    rx_pop(ch);
                    check("R2 rxvld", 32'(rx_rd_vld[ch]), 32'h1);
                    check("R2 rxdata", 32'(rx_rd_data[ch*8 +: 8]), 32'(d));
                end
                2'd2: tx_push(ch, d);
                default: begin
                    tx_pop(ch);
                    check("R3 txdata", 32'(tx_rd_data[ch*8 +: 8]), 32'(d));
                end
            endcase
        end
        check("R5 no ovf yet", 32'(ovf_flags), 32'h0);

        // R4: underflow on tx ch1 repeats last byte
        tx_pop(1);
        check("R4 hold", 32'(tx_rd_data[15:8]), 32'h5A);
        check("R4 unf flag", 32'(unf_flags), 32'h0200);
        tx_pop(1);
        check("R4 hold again", 32'(tx_rd_data[15:8]), 32'h5A);

        // R9: recovery after underflow
        tx_push(1, 8'hC3);
        tx_pop(1);
        check("R9 new byte", 32'(tx_rd_data[15:8]), 32'hC3);
        check("R9 flag kept", 32'(unf_flags), 32'h0200);

        // R8: host read of empty rx fifo
        rx_pop(3);
        check("R8 empty rx vld", 32'(rx_rd_vld), 32'h0);
        check("R8 empty rx flags", 32'(ovf_flags), 32'h0);

        // R5: overflow on rx ch1
        for (int k = 0; k < DEPTH + 2; k++) rx_push(1, 8'(8'h80 + k));
        check("R5 ovf flag", 32'(ovf_flags), 32'h0002);
        for (int k = 0; k < DEPTH; k++) begin
            rx_pop(1);
            check("R5 kept data", 32'(rx_rd_data[15:8]), 32'(8'(8'h80 + k)));
        end
        rx_pop(1);
        check("R5 dropped extra", 32'(rx_rd_vld), 32'h0);

        // R6: per-channel clear
        chan_en = 16'h1F1F & ~16'h0200;
        idle();
        check("R6 unf cleared", 32'(unf_flags), 32'h0);
        check("R6 other kept", 32'(ovf_flags), 32'h0002);
        chan_en = 16'h1F1F;
        idle();
        check("R6 tx byte reset", 32'(tx_rd_data[15:8]), 32'h0);
        chan_en = 16'h1F1D;
        idle();
        check("R6 ovf cleared", 32'(ovf_flags), 32'h0);
        chan_en = 16'h1F1F;
        idle();

        // R8/R1: disabled channel ignores traffic
        chan_en = 16'h1F1B;
        idle();
        for (int k = 0; k < DEPTH + 3; k++) rx_push(2, 8'(k));
        check("R8 no flag disabled", 32'(ovf_flags), 32'h0);
        chan_en = 16'h1F1F;
        idle();
        rx_pop(2);
        check("R1 disabled data dropped", 32'(rx_rd_vld), 32'h0);

        // R7: global disable clears flags and flushes
        for (int k = 0; k < DEPTH + 1; k++) tx_push(0, 8'(8'h40 + k));
        check("R5 tx ovf", 32'(ovf_flags), 32'h0100);
        glb_en = 1'b0;
        idle();
        check("R7 ovf clear", 32'(ovf_flags), 32'h0);
        check("R7 unf clear", 32'(unf_flags), 32'h0);
        glb_en = 1'b1;
        idle();
        tx_pop(0);
        check("R7 flushed", 32'(tx_rd_data[7:0]), 32'h0);
        check("R7 flush unf", 32'(unf_flags), 32'h0100);

        // R1: bit 8 enables tx0 only, not rx0
        chan_en = 16'h0100;
        idle();
        rx_push(0, 8'h55);
        chan_en = 16'h1F1F;
        idle();
        rx_pop(0);
        check("R1 mapping", 32'(rx_rd_vld), 32'h0);

        finish_run();
    end
endmodule